// File: doc/BRIEF.md
# Shared Stacked-Die Data Bus Lock Arbiter

Several rank command engines in one memory channel share a single vertical data bus between the stacked dies. This arbiter decides which rank may move data next. A rank asks for the bus by holding its request line high, and it states with a second line whether its transfer is a short or a long burst. When the bus is free, the request that has waited longest wins. The bus then stays locked to that rank for the whole burst. A down-counter loaded with the burst length tracks the lock, and the bus frees itself when the counter runs out.

Arbitration runs again in the last cycle of every burst, so a waiting rank can take the bus on the very next cycle with no idle gap. There is no penalty for switching between ranks. The owner can also give up the bus early by dropping its request. A free-running count of locked cycles lets the rest of the controller measure how much of the data bus bandwidth is used.

Top module: `bus_lock_arbiter`

## Requirements
- R1: While reset is held, and on the first sample after it is released, `grant` is all zeros, `bus_busy` is 0 and `busy_cycles` is 0.
- R2: At most one bit of `grant` is set in any cycle. Bit i of `grant` means rank i owns the bus.
- R3: A grant made to rank i lasts exactly 2 cycles when `req_long[i]` was 0 at the time of the grant, and exactly 4 cycles when it was 1, provided `req_valid[i]` stays high.
- R4: `bus_busy` is 1 exactly in the cycles in which `grant` is nonzero.
- R5: When the bus is free, the grant goes to the valid request that has been waiting the most cycles since its request line rose. Equal waiting times are resolved in favour of the lowest rank index. A grant appears one cycle after the request is seen on a free bus.
- R6: If another request is waiting when a burst ends, the next grant is visible in the cycle right after the last burst cycle, even when it goes to a different rank.
- R7: A request that rises while the bus is locked does not take the bus before the current burst ends.
- R8: If the owner drops `req_valid` during its burst, its grant is removed in the following cycle and the bus becomes free or passes to the oldest waiter.
- R9: `busy_cycles` goes up by exactly one in the cycle after each cycle with `bus_busy` high, and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_RANKS | Per-rank data transfer request, held until served |
| req_long | input | NUM_RANKS | Per-rank burst size select: 1 = long burst, 0 = short burst |
| grant | output | NUM_RANKS | One-hot bus ownership |
| bus_busy | output | 1 | Data bus is locked this cycle |
| busy_cycles | output | CNT_W | Running count of locked cycles |

## Verification
The hardest cases to reach are the handover in the last burst cycle and waiting-time ordering among several ranks. Both need requests to arrive at chosen cycles while the bus is still locked. The bench sweeps every ordered pair of ranks and every pair of burst sizes. In each case it raises the second request during the first rank's burst, so the next grant must land on the exact cycle after the first burst ends. Separate runs stagger three late arrivals behind a long burst, raise all four requests together to check the lowest-index tie-break, and drop the owner's request in the middle of a burst.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

    typedef enum logic {
        BURST_SHORT = 1'b0,
        BURST_LONG  = 1'b1
    } burst_kind_e;

    localparam int unsigned DEF_SHORT_BURST = 2;
    localparam int unsigned DEF_LONG_BURST  = 4;

    function automatic int unsigned burst_cycles(
        input burst_kind_e kind,
        input int unsigned short_len,
        input int unsigned long_len
    );
        return (kind == BURST_LONG) ? long_len : short_len;
    endfunction

endpackage

// File: rtl/rank_age_tracker.sv
module rank_age_tracker #(
    parameter int unsigned AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             clear,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [AGE_W-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (!valid || clear) begin
            age_d = '0;
        end else if (age_q != AGE_MAX) begin
            age_d = age_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    assign age = age_q;

endmodule

// File: rtl/age_picker.sv
module age_picker #(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned AGE_W     = 5,
    localparam int unsigned IDX_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic [NUM_RANKS-1:0]            valid,
    input  logic [NUM_RANKS-1:0][AGE_W-1:0] ages,
    output logic                            any,
    output logic [IDX_W-1:0]                win_idx,
    output logic [NUM_RANKS-1:0]            win_onehot
);
    logic [AGE_W-1:0] best_age;

    always_comb begin
        any      = 1'b0;
        best_age = '0;
        win_idx  = '0;
        for (int i = 0; i < NUM_RANKS; i++) begin
            // strict compare keeps the lowest index on equal ages
            if (valid[i] && (!any || ages[i] > best_age)) begin
                any      = 1'b1;
                best_age = ages[i];
                win_idx  = IDX_W'(i);
            end
        end
        win_onehot = '0;
        if (any) begin
            win_onehot[win_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/bus_lock_counter.sv
module bus_lock_counter #(
    parameter int unsigned LONG_LEN = 4,
    localparam int unsigned LEN_W   = $clog2(LONG_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             hold,
    output logic [LEN_W-1:0] remaining
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_len;
        end else if (hold) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign remaining = cnt_q;

endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
    import bus_lock_pkg::*;
#(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned AGE_W     = 5,
    parameter int unsigned SHORT_LEN = DEF_SHORT_BURST,
    parameter int unsigned LONG_LEN  = DEF_LONG_BURST,
    parameter int unsigned CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RANKS-1:0] req_valid,
    input  logic [NUM_RANKS-1:0] req_long,
    output logic [NUM_RANKS-1:0] grant,
    output logic                 bus_busy,
    output logic [CNT_W-1:0]     busy_cycles
);
    localparam int unsigned IDX_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
    localparam int unsigned LEN_W = $clog2(LONG_LEN + 1);

    typedef struct packed {
        logic [NUM_RANKS-1:0] grant;
        logic [IDX_W-1:0]     owner;
        logic [CNT_W-1:0]     busy_cnt;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_RANKS-1:0][AGE_W-1:0] ages;
    logic [NUM_RANKS-1:0]            age_clear;
    logic                            pick_any;
    logic [IDX_W-1:0]                pick_idx;
    logic [NUM_RANKS-1:0]            pick_onehot;
    logic [LEN_W-1:0]                lock_left;
    logic [LEN_W-1:0]                load_len;
    logic                            hold;
    logic                            load;

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_age
        rank_age_tracker #(
            .AGE_W(AGE_W)
        ) u_age (
            .clk  (clk),
            .rst_n(rst_n),
            .valid(req_valid[g]),
            .clear(age_clear[g]),
            .age  (ages[g])
        );
    end

    age_picker #(
        .NUM_RANKS(NUM_RANKS),
        .AGE_W    (AGE_W)
    ) u_pick (
        .valid     (req_valid),
        .ages      (ages),
        .any       (pick_any),
        .win_idx   (pick_idx),
        .win_onehot(pick_onehot)
    );

    bus_lock_counter #(
        .LONG_LEN(LONG_LEN)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_len (load_len),
        .hold     (hold),
        .remaining(lock_left)
    );

    always_comb begin
        // owner keeps the bus while more than one burst cycle remains
        hold     = (lock_left > LEN_W'(1)) && req_valid[st_q.owner];
        load     = !hold && pick_any;
        load_len = LEN_W'(burst_cycles(burst_kind_e'(req_long[pick_idx]),
                                       SHORT_LEN, LONG_LEN));

        st_d = st_q;
        if (hold) begin
            st_d.grant = st_q.grant;
        end else if (load) begin
            st_d.grant = pick_onehot;
            st_d.owner = pick_idx;
        end else begin
            st_d.grant = '0;
        end
        st_d.busy_cnt = st_q.busy_cnt
                      + {{(CNT_W-1){1'b0}}, (lock_left != '0)};

        for (int i = 0; i < NUM_RANKS; i++) begin
            if (load) begin
                age_clear[i] = pick_onehot[i];
            end else begin
                age_clear[i] = hold && (st_q.owner == IDX_W'(i));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant       = st_q.grant;
    assign bus_busy    = (lock_left != '0);
    assign busy_cycles = st_q.busy_cnt;

endmodule

// File: rtl/bus_lock_arbiter_chk.sv
module bus_lock_arbiter_chk #(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned CNT_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RANKS-1:0] req_valid,
    input logic [NUM_RANKS-1:0] grant,
    input logic                 bus_busy,
    input logic [CNT_W-1:0]     busy_cycles
);
    logic [NUM_RANKS-1:0] prev_grant_q;
    logic                 new_grant;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_grant_q <= '0;
        end else begin
            prev_grant_q <= grant;
        end
    end

    assign new_grant = (grant != '0) && (grant != prev_grant_q);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy == (grant != '0)); // R4

    AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> busy_cycles == $past(busy_cycles) + CNT_W'($past(bus_busy))); // R9

    AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (($past(req_valid) & grant) != '0)); // R5

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (new_grant && ((grant & req_valid) != '0)) |=> grant == $past(grant)); // R7

endmodule

bind bus_lock_arbiter bus_lock_arbiter_chk #(
    .NUM_RANKS(NUM_RANKS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .grant      (grant),
    .bus_busy   (bus_busy),
    .busy_cycles(busy_cycles)
);

// File: tb/bus_lock_arbiter_test.sv
module bus_lock_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_valid = '0;
    logic [N-1:0] req_long = '0;
    logic [N-1:0] grant;
    logic         bus_busy;
    logic [31:0]  busy_cycles;

    int checks = 0;
    int fails  = 0;
    int exp_busy = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_lock_arbiter #(.NUM_RANKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_long(req_long),
        .grant(grant), .bus_busy(bus_busy), .busy_cycles(busy_cycles)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one edge, then sample outputs and run per-cycle checks
    task automatic step();
        @(posedge clk);
        #1;
        chk(busy_cycles == 32'(exp_busy), "R9 busy count", int'(busy_cycles), exp_busy);
        chk(bus_busy == (grant != '0), "R4 busy flag", int'(bus_busy), int'(grant != '0));
        chk($countones(grant) <= 1, "R2 one-hot", int'(grant), 0);
        exp_busy += int'(bus_busy);
    endtask

    // a granted first, b raised during a's burst, b takes over gaplessly
    task automatic run_pair(input int a, input int b, input bit la, input bit lb);
        int len_a = la ? 4 : 2;
        int len_b = lb ? 4 : 2;
        req_long[a] = la;
        req_long[b] = lb;
        req_valid[a] = 1'b1;
        step();
        for (int c = 0; c < len_a; c++) begin
            chk(grant == N'(1 << a), c == 0 ? "R5 first grant" : "R3 burst hold",
                int'(grant), 1 << a);
            if (c == 0) req_valid[b] = 1'b1;
            if (c == len_a - 1) req_valid[a] = 1'b0;
            step();
        end
        for (int c = 0; c < len_b; c++) begin
            chk(grant == N'(1 << b), c == 0 ? "R6 gapless handover" : "R3 burst hold",
                int'(grant), 1 << b);
            if (c == len_b - 1) req_valid[b] = 1'b0;
            step();
        end
        chk(grant == '0, "R3 burst end", int'(grant), 0);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(grant == '0, "R1 reset grant", int'(grant), 0);
        chk(bus_busy == 1'b0, "R1 reset busy", int'(bus_busy), 0);
        rst_n = 1'b1;
        step();
        chk(busy_cycles == 0, "R1 reset count", int'(busy_cycles), 0);
        chk(grant == '0, "R1 idle grant", int'(grant), 0);

        // sweep over every ordered rank pair and burst sizes
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                if (a != b)
                    for (int k = 0; k < 4; k++)
                        run_pair(a, b, k[0], k[1]);

        // R7/R5: rank 3 long burst, 1, 2, 0 arrive in turn while locked
        req_long = 4'b1000;
        req_valid[3] = 1'b1;
        step();
        for (int c = 0; c < 4; c++) begin
            chk(grant == 4'b1000, "R7 no preempt", int'(grant), 8);
            if (c == 0) req_valid[1] = 1'b1;
            if (c == 1) req_valid[2] = 1'b1;
            if (c == 2) req_valid[0] = 1'b1;
            if (c == 3) req_valid[3] = 1'b0;
            step();
        end
        begin
            int order[3] = '{1, 2, 0};
            for (int o = 0; o < 3; o++) begin
                for (int c = 0; c < 2; c++) begin
                    chk(grant == N'(1 << order[o]), "R5 oldest first",
                        int'(grant), 1 << order[o]);
                    if (c == 1) req_valid[order[o]] = 1'b0;
                    step();
                end
            end
        end
        chk(grant == '0, "R5 queue drained", int'(grant), 0);
        step();

        // R5 tie: all raise together, lowest index first
        req_long = '0;
        req_valid = 4'b1111;
        step();
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < 2; c++) begin
                chk(grant == N'(1 << r), "R5 tie lowest index", int'(grant), 1 << r);
                if (c == 1) req_valid[r] = 1'b0;
                step();
            end
        end
        chk(grant == '0, "R5 tie drained", int'(grant), 0);
        step();

        // R8: owner withdraws mid burst, alone then with a waiter
        req_long = 4'b0100;
        req_valid[2] = 1'b1;
        step();
        chk(grant == 4'b0100, "R8 grant", int'(grant), 4);
        req_valid[2] = 1'b0;
        step();
        chk(grant == '0, "R8 early release idle", int'(grant), 0);
        chk(bus_busy == 1'b0, "R8 bus free", int'(bus_busy), 0);
        req_valid[2] = 1'b1;
        step();
        chk(grant == 4'b0100, "R8 regrant", int'(grant), 4);
        req_valid[0] = 1'b1;
        step();
        req_valid[2] = 1'b0;
        step();
        chk(grant == 4'b0001, "R8 early handover", int'(grant), 1);
        step();
        req_valid[0] = 1'b0;
        step();
        step();
        chk(grant == '0, "R8 end idle", int'(grant), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule